// File: doc/BRIEF.md
# Periodic System Tick Timer

This block is a free-running 24-bit down-counter that produces a regular tick for a processor. Software loads a reload value, clears the live count and sets the run bit; from then on the count steps down by one on every system clock. When it reaches zero it is refilled from the reload value on the next clock, so the tick period is the reload value plus one clock cycles. Each time the count steps from one to zero, a sticky count flag is set and, if the tick request is switched on, a one-cycle tick request is raised.

Software reaches the block through four 32-bit words on a simple bus: a control/status word, the reload word, the live count and a read-only calibration word. There is no mask stage behind the block, so the tick-request enable bit in the control word is the only way to silence the request. The reload word and the live count are not given a reset value; software writes both before starting the timer.

Top module: `tick_timer_top`

## Requirements
- R1: After reset the control/status word (word index 0, byte offset 0x0) reads 0x0000_0004 and `tick_irq` is low.
- R2: The reload word (index 1, offset 0x4) keeps bits 23:0 of the written data; bits 31:24 read as zero.
- R3: Any write to the live count word (index 2, offset 0x8) sets the count to zero and clears the count flag, whatever data is written; its reads return the live count with bits 31:24 zero.
- R4: While the run bit (control bit 0) is set, the count falls by one per clock and, from zero, is refilled with the reload value, so successive reads follow the period reload+1.
- R5: The count flag (control bit 16) sets when the count steps from 1 to 0 and clears when the control/status word is read; if both happen on the same clock the read returns the old flag value and the flag stays set.
- R6: With the tick-request enable (control bit 1) set, `tick_irq` pulses high for exactly one cycle per step from 1 to 0; with it clear, `tick_irq` stays low while the count flag still sets.
- R7: With a reload value of zero, the count stays at zero after the next expiry and no further flags or tick requests occur.
- R8: The calibration word (index 3, offset 0xC) reads the constant parameter `CALIB_WORD` (default 0xC000_0000); writes to it have no effect.
- R9: While the run bit is clear, the count holds its value.
- R10: Control bit 2 always reads 1 and bits other than 0 and 1 ignore writes; read data appears on `bus_rdata` in the cycle after the read request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; the count steps on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_en | input | 1 | Bus request valid for one cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Word index: 0 control/status, 1 reload, 2 live count, 3 calibration |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered, valid the cycle after a read request |
| tick_irq | output | 1 | One-cycle tick request |

## Verification
The count flag can be set by the count stepping from one to zero and cleared by a control/status read on the very same clock. The bench provokes this by clearing the count, loading a known reload value and timing a control/status read so that the bus strobe lands on the exact edge of expiry, counted from the enabling write. The judgement is that this read returns the flag clear, the next read returns it set, and a third read returns it clear again.

// File: rtl/tick_pkg.sv
package tick_pkg;

  localparam int DATA_W   = 32;
  localparam int IDX_W    = 2;
  localparam int NUM_REGS = 4;

  // Word indices of the register map; byte offset = index * 4
  typedef enum logic [IDX_W-1:0] {
    REG_CTRL    = 2'd0,
    REG_RELOAD  = 2'd1,
    REG_CURRENT = 2'd2,
    REG_CALIB   = 2'd3
  } reg_idx_e;

  // Control/status word bit positions
  localparam int CTRL_RUN_BIT  = 0;
  localparam int CTRL_IRQ_BIT  = 1;
  localparam int CTRL_SRC_BIT  = 2;
  localparam int CTRL_FLAG_BIT = 16;

  // Assemble the control/status read word
  function automatic logic [DATA_W-1:0] pack_ctrl(input logic run,
                                                  input logic irq_en,
                                                  input logic flag);
    logic [DATA_W-1:0] w;
    w = '0;
    w[CTRL_RUN_BIT]  = run;
    w[CTRL_IRQ_BIT]  = irq_en;
    w[CTRL_SRC_BIT]  = 1'b1;
    w[CTRL_FLAG_BIT] = flag;
    return w;
  endfunction

endpackage

// File: rtl/tick_bus_port.sv
module tick_bus_port
  import tick_pkg::*;
#(
  parameter int N_REGS = NUM_REGS
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          bus_en,
  input  logic                          bus_we,
  input  logic [IDX_W-1:0]              bus_addr,
  input  logic [N_REGS-1:0][DATA_W-1:0] rd_words,
  output logic [N_REGS-1:0]             wr_stb,
  output logic [N_REGS-1:0]             rd_stb,
  output logic [DATA_W-1:0]             bus_rdata
);

  // One strobe per register word
  for (genvar i = 0; i < N_REGS; i++) begin : g_strobe
    assign wr_stb[i] = bus_en &&  bus_we && (bus_addr == IDX_W'(i));
    assign rd_stb[i] = bus_en && !bus_we && (bus_addr == IDX_W'(i));
  end

  logic rd_any;
  assign rd_any = |rd_stb;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bus_rdata <= '0;
    end else if (rd_any) begin
      bus_rdata <= rd_words[bus_addr];
    end
  end

  // R10
  rdata_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_any |=> bus_rdata == $past(rd_words[bus_addr]));

  // R10
  strobe_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wr_stb, rd_stb}));

endmodule

// File: rtl/tick_down_counter.sv
module tick_down_counter #(
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             reload_wr,
  input  logic [CNT_W-1:0] reload_data,
  input  logic             count_clr,
  output logic [CNT_W-1:0] count,
  output logic [CNT_W-1:0] reload,
  output logic             expire_hit
);

  localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);
  localparam logic [CNT_W-1:0] ZERO = '0;

  // Next value of the live count
  function automatic logic [CNT_W-1:0] step_count(input logic [CNT_W-1:0] cur,
                                                  input logic [CNT_W-1:0] rld,
                                                  input logic go,
                                                  input logic clr);
    if (clr)             return ZERO;
    else if (!go)        return cur;
    else if (cur == ZERO) return rld;
    else                 return cur - ONE;
  endfunction

  // Step from one to zero this clock
  function automatic logic is_expiry(input logic [CNT_W-1:0] cur,
                                     input logic go,
                                     input logic clr);
    return go && !clr && (cur == ONE);
  endfunction

  logic [CNT_W-1:0] count_q;
  logic [CNT_W-1:0] reload_q;

  // Count and reload storage carry no reset: software loads them first
  always_ff @(posedge clk) begin
    if (reload_wr) reload_q <= reload_data;
    count_q <= step_count(count_q, reload_q, run, count_clr);
  end

  assign count      = count_q;
  assign reload     = reload_q;
  assign expire_hit = is_expiry(count_q, run, count_clr);

  // R3
  count_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count_clr |=> count_q == ZERO);

  // R4
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !count_clr && count_q != ZERO) |=> count_q == $past(count_q) - ONE);

  // R4
  count_refill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !count_clr && count_q == ZERO) |=> count_q == $past(reload_q));

  // R9
  count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !count_clr) |=> $stable(count_q));

  // R7
  zero_reload_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !count_clr && !reload_wr && count_q == ZERO && reload_q == ZERO)
      |=> (count_q == ZERO && !expire_hit));

endmodule

// File: rtl/tick_ctrl_reg.sv
module tick_ctrl_reg
  import tick_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctrl_wr,
  input  logic              ctrl_rd,
  input  logic [1:0]        ctrl_wdata,
  input  logic              expire_hit,
  input  logic              count_clr,
  output logic              run,
  output logic              irq_en,
  output logic              flag,
  output logic [DATA_W-1:0] ctrl_word
);

  logic run_q, irq_en_q, flag_q;

  // Set from expiry takes precedence over either clearing source
  function automatic logic next_flag(input logic cur, input logic set,
                                     input logic rd_clr, input logic wr_clr);
    if (set)                  return 1'b1;
    else if (rd_clr || wr_clr) return 1'b0;
    else                      return cur;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q    <= 1'b0;
      irq_en_q <= 1'b0;
      flag_q   <= 1'b0;
    end else begin
      if (ctrl_wr) begin
        run_q    <= ctrl_wdata[CTRL_RUN_BIT];
        irq_en_q <= ctrl_wdata[CTRL_IRQ_BIT];
      end
      flag_q <= next_flag(flag_q, expire_hit, ctrl_rd, count_clr);
    end
  end

  assign run       = run_q;
  assign irq_en    = irq_en_q;
  assign flag      = flag_q;
  assign ctrl_word = pack_ctrl(run_q, irq_en_q, flag_q);

  // R5
  flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    expire_hit |=> flag_q);

  // R5
  flag_read_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_rd && !expire_hit) |=> !flag_q);

  // R3
  flag_count_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count_clr |=> !flag_q);

  // R10
  ctrl_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr |=> (run_q == $past(ctrl_wdata[CTRL_RUN_BIT]) &&
                 irq_en_q == $past(ctrl_wdata[CTRL_IRQ_BIT])));

endmodule

// File: rtl/tick_irq_gen.sv
module tick_irq_gen (
  input  logic clk,
  input  logic rst_n,
  input  logic expire_hit,
  input  logic irq_en,
  input  logic flag,
  output logic tick_irq
);

  logic irq_q;

  always_ff @(posedge clk) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= expire_hit && irq_en;
  end

  assign tick_irq = irq_q;

  // R6
  irq_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |=> !irq_q);

  // R6
  irq_with_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |-> flag);

  // R6
  irq_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (expire_hit && !irq_en) |=> !irq_q);

endmodule

// File: rtl/tick_timer_top.sv
module tick_timer_top
  import tick_pkg::*;
#(
  parameter int                CNT_W      = 24,
  parameter logic [DATA_W-1:0] CALIB_WORD = 32'hC000_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [IDX_W-1:0]  bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              tick_irq
);

  localparam int PAD_W = DATA_W - CNT_W;

  logic [NUM_REGS-1:0]             wr_stb, rd_stb;
  logic [NUM_REGS-1:0][DATA_W-1:0] rd_words;
  logic [CNT_W-1:0]                count, reload;
  logic                            run, irq_en, flag, expire_hit;
  logic [DATA_W-1:0]               ctrl_word;

  tick_bus_port #(.N_REGS(NUM_REGS)) u_bus (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_en    (bus_en),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .rd_words  (rd_words),
    .wr_stb    (wr_stb),
    .rd_stb    (rd_stb),
    .bus_rdata (bus_rdata)
  );

  tick_down_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk         (clk),
    .rst_n       (rst_n),
    .run         (run),
    .reload_wr   (wr_stb[REG_RELOAD]),
    .reload_data (bus_wdata[CNT_W-1:0]),
    .count_clr   (wr_stb[REG_CURRENT]),
    .count       (count),
    .reload      (reload),
    .expire_hit  (expire_hit)
  );

  tick_ctrl_reg u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .ctrl_wr    (wr_stb[REG_CTRL]),
    .ctrl_rd    (rd_stb[REG_CTRL]),
    .ctrl_wdata (bus_wdata[1:0]),
    .expire_hit (expire_hit),
    .count_clr  (wr_stb[REG_CURRENT]),
    .run        (run),
    .irq_en     (irq_en),
    .flag       (flag),
    .ctrl_word  (ctrl_word)
  );

  tick_irq_gen u_irq (
    .clk        (clk),
    .rst_n      (rst_n),
    .expire_hit (expire_hit),
    .irq_en     (irq_en),
    .flag       (flag),
    .tick_irq   (tick_irq)
  );

  // Read words; the calibration word has no write path at all
  assign rd_words[REG_CTRL]    = ctrl_word;
  assign rd_words[REG_RELOAD]  = {{PAD_W{1'b0}}, reload};
  assign rd_words[REG_CURRENT] = {{PAD_W{1'b0}}, count};
  assign rd_words[REG_CALIB]   = CALIB_WORD;

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_n |=> (!tick_irq && !run && !irq_en && !flag));

endmodule

// File: tb/tb_tick_timer_top.sv
module tb_tick_timer_top;

  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] CALIB = 32'hC000_0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_en = 1'b0;
  logic        bus_we = 1'b0;
  logic [1:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        tick_irq;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tick_timer_top dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_en    (bus_en),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .tick_irq  (tick_irq)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // Drive at the falling edge, the rising edge takes the request
  task automatic bus_write(input logic [1:0] idx, input logic [31:0] data);
    bus_en = 1'b1; bus_we = 1'b1; bus_addr = idx; bus_wdata = data;
    @(posedge clk);
    @(negedge clk);
    bus_en = 1'b0; bus_we = 1'b0;
  endtask

  task automatic bus_read(input logic [1:0] idx, output logic [31:0] data);
    bus_en = 1'b1; bus_we = 1'b0; bus_addr = idx;
    @(posedge clk);
    @(negedge clk);
    bus_en = 1'b0;
    data = bus_rdata;
  endtask

  task automatic start_timer(input logic [31:0] rld, input bit irq_on);
    bus_write(2'd0, 32'h0);
    bus_write(2'd1, rld);
    bus_write(2'd2, 32'h0);
    bus_write(2'd0, {30'h0, irq_on, 1'b1});
  endtask

  task automatic test_reset;
    logic [31:0] v;
    check(tick_irq == 1'b0, "R1 irq low", tick_irq, 0);
    bus_read(2'd0, v);
    check(v == 32'h4, "R1 ctrl reset", v, 32'h4);
  endtask

  task automatic test_reload_and_clear;
    logic [31:0] v;
    bus_write(2'd1, 32'hAB12_3456);
    bus_read(2'd1, v);
    check(v == 32'h0012_3456, "R2 reload bits", v, 32'h0012_3456);
    bus_write(2'd2, 32'hFFFF_FFFF);
    bus_read(2'd2, v);
    check(v == 32'h0, "R3 count cleared", v, 0);
  endtask

  task automatic test_countdown;
    logic [31:0] prev, cur;
    bit ok = 1'b1;
    logic [31:0] bad_act = '0, bad_exp = '0;
    start_timer(32'd5, 1'b0);
    bus_read(2'd2, prev);
    for (int i = 0; i < 14; i++) begin
      logic [31:0] want;
      bus_read(2'd2, cur);
      want = (prev == 0) ? 32'd5 : prev - 1;
      if (cur != want && ok) begin ok = 1'b0; bad_act = cur; bad_exp = want; end
      prev = cur;
    end
    check(ok, "R4 countdown sequence", bad_act, bad_exp);
    // R9: stop, then the count must not move
    bus_write(2'd0, 32'h0);
    bus_read(2'd2, prev);
    repeat (10) @(negedge clk);
    bus_read(2'd2, cur);
    check(cur == prev, "R9 hold when stopped", cur, prev);
  endtask

  task automatic test_irq_period;
    int last = -1, pulses = 0;
    bit gap_ok = 1'b1;
    int bad_gap = 0;
    start_timer(32'd3, 1'b1);
    for (int c = 0; c < 60; c++) begin
      @(negedge clk);
      if (tick_irq) begin
        if (last >= 0 && (c - last) != 4 && gap_ok) begin gap_ok = 1'b0; bad_gap = c - last; end
        last = c;
        pulses++;
      end
    end
    check(gap_ok, "R6 irq spacing reload+1", bad_gap, 4);
    check(pulses >= 14, "R6 irq count", pulses, 15);
    bus_write(2'd0, 32'h0);
  endtask

  task automatic test_irq_masked;
    logic [31:0] v;
    int pulses = 0;
    start_timer(32'd3, 1'b0);
    for (int c = 0; c < 30; c++) begin
      @(negedge clk);
      if (tick_irq) pulses++;
    end
    check(pulses == 0, "R6 no irq when disabled", pulses, 0);
    bus_write(2'd0, 32'h0);
    bus_read(2'd0, v);
    check(v[16] == 1'b1, "R6 flag still set", v[16], 1);
    bus_read(2'd0, v);
    check(v[16] == 1'b0, "R5 flag cleared by read", v[16], 0);
  endtask

  task automatic test_flag_collision;
    logic [31:0] v;
    localparam int RLD = 20;
    start_timer(RLD, 1'b0);
    // enable took effect at edge E0; expiry lands on edge E0+RLD+1
    repeat (RLD) @(negedge clk);
    bus_read(2'd0, v);
    check(v[16] == 1'b0, "R5 collision read old flag", v[16], 0);
    bus_read(2'd0, v);
    check(v[16] == 1'b1, "R5 set wins over read clear", v[16], 1);
    bus_read(2'd0, v);
    check(v[16] == 1'b0, "R5 cleared after read", v[16], 0);
    bus_write(2'd0, 32'h0);
  endtask

  task automatic test_cvr_clears_flag;
    logic [31:0] v;
    start_timer(32'd2, 1'b0);
    repeat (8) @(negedge clk);
    bus_write(2'd0, 32'h0);
    bus_write(2'd2, 32'h1234_5678);
    bus_read(2'd0, v);
    check(v[16] == 1'b0, "R3 flag cleared by count write", v[16], 0);
  endtask

  task automatic test_zero_reload;
    logic [31:0] v;
    int pulses = 0;
    start_timer(32'd3, 1'b1);
    bus_write(2'd1, 32'h0);
    repeat (8) @(negedge clk);
    bus_read(2'd0, v);
    for (int c = 0; c < 20; c++) begin
      @(negedge clk);
      if (tick_irq) pulses++;
    end
    check(pulses == 0, "R7 no irq after zero reload", pulses, 0);
    bus_read(2'd2, v);
    check(v == 32'h0, "R7 count parked at zero", v, 0);
    bus_read(2'd0, v);
    check(v[16] == 1'b0, "R7 no new flag", v[16], 0);
    bus_write(2'd0, 32'h0);
  endtask

  task automatic test_calib_and_ctrl_bits;
    logic [31:0] v;
    bus_read(2'd3, v);
    check(v == CALIB, "R8 calib value", v, CALIB);
    bus_write(2'd3, 32'h0000_1234);
    bus_read(2'd3, v);
    check(v == CALIB, "R8 calib write ignored", v, CALIB);
    bus_write(2'd1, 32'h00FF_FFFF);
    bus_write(2'd2, 32'h0);
    bus_write(2'd0, 32'hFFFE_FFF8);
    bus_read(2'd0, v);
    check(v == 32'h4, "R10 only bits 0/1 writable, bit 2 reads 1", v, 32'h4);
    bus_write(2'd0, 32'h0000_0003);
    bus_read(2'd0, v);
    check(v == 32'h7, "R10 ctrl readback", v, 32'h7);
    bus_write(2'd0, 32'h0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    test_reset();
    test_reload_and_clear();
    test_countdown();
    test_irq_period();
    test_irq_masked();
    test_flag_collision();
    test_cvr_clears_flag();
    test_zero_reload();
    test_calib_and_ctrl_bits();
    finished = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule